// File: doc/BRIEF.md
# I2C Master Write Engine

This block is an I2C bus master that only writes. Software gives it bytes through a one-byte data register and steers it with three control bits: start, stop and interrupt enable. The block sends each byte on SDA, most significant bit first, while it generates SCL itself. After each byte it samples the slave's acknowledge and reports it in status outputs. Seven-bit and ten-bit slave addresses are both supported, because software writes the address bytes into the data register in the order they go out, ahead of the payload.

A byte moves from the data register into a shift register at the moment its first bit is put on the bus. The data register then shows empty, and the transmit interrupt asks for the next byte while the current one is still being sent. If the slave answers a byte with a Not Acknowledge, the engine parks with SCL low and sends nothing more. Software then chooses one of two actions. It can request a stop, which discards any byte still waiting. Or it can load a new address and request a start, which produces a repeated START. If the data register is empty when a byte finishes, the engine holds SCL low until software writes another byte or asks for a stop.

Both bus pins are open-drain. An output-enable of 1 pulls the line low, and SDA is read back on its input. Each SCL phase, high and low, lasts the number of system clocks on the divider input, with a floor of two.

Top module: `i2c_wr_master`

## Requirements
- R1: After reset both bus pins are released (scl_oe=0, sda_oe=0). The data register reads empty (st_tdre=1). st_busy, irq, st_ack, st_ackv, st_nack, st_start and st_stop are all 0.
- R2: Start condition. Control bit 0 (START) is written as 1 while a byte is pending. The engine then pulls SDA low while SCL is released, and only after that drives SCL low. The START status bit clears when the start condition begins.
- R3: Each byte leaves on SDA most significant bit first, in the order the bytes were written. During a byte's data bits, SDA never changes while SCL is released. Ten-bit addressing is the sequence of first address byte (11110, two upper address bits, write bit 0), second address byte, then data.
- R4: st_tdre sets when a byte moves into the shift register, on the clock where SCL falls for its first bit, and clears on a data write. With interrupt enable (control bit 2) set, irq is 1 while st_nack is 1, or while st_tdre is 1 during a transfer. irq is 0 when idle.
- R5: The slave's answer is sampled at the end of the ninth SCL high phase. If SDA is low, st_ack=1 and st_ackv=1. Both clear when the next byte loads.
- R6: If SDA is high at that sample, st_nack=1, st_ack=0 and st_ackv=1, and irq rises. The engine then holds SCL low and starts no further byte, even with a byte pending.
- R7: Control bit 1 (STOP) is written while st_nack is 1. The engine discards the pending byte (st_tdre=1), sends a stop condition, and clears both STOP and st_nack.
- R8: If the data register is empty when a byte's acknowledge ends, SCL stays low until a byte is written (and then goes out) or STOP is requested.
- R9: A stop is requested after an acknowledged byte. The engine releases SDA while SCL is released, clears STOP, and returns to idle with both pins released and st_busy=0.
- R10: START is written while the engine is paused between bytes (including after a NACK) and a byte is pending. The engine releases SDA, releases SCL, then issues a repeated START and sends that byte. st_nack clears.
- R11: Every SCL high phase, and every low phase inside a byte and its acknowledge, lasts max(clk_div, 2) system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | DIV_W | System clocks per SCL phase (values below 2 act as 2) |
| wr_en | input | 1 | Register write strobe |
| wr_ctl | input | 1 | 0 selects the data register, 1 the control bits |
| wr_data | input | 8 | Write value; control: bit 0 START (set), bit 1 STOP (set), bit 2 interrupt enable |
| st_tdre | output | 1 | Data register empty |
| st_ack | output | 1 | Last answer was an acknowledge |
| st_ackv | output | 1 | st_ack holds a valid answer |
| st_nack | output | 1 | Halted on a Not Acknowledge |
| st_start | output | 1 | START request pending |
| st_stop | output | 1 | STOP request pending |
| st_busy | output | 1 | Engine away from idle |
| irq | output | 1 | Transmit / NACK interrupt |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| sda_i | input | 1 | SDA line level |

## Verification
A wrong bit counter or shift register shows within one byte, as a corrupted or misaligned byte at the bus monitor, and the acknowledge clock lands on the wrong SCL pulse. A sequencer state that is wrong around the acknowledge shows at once. Symptoms include a byte started after a NACK, a missing stop, or SCL released while the engine should be parked. Status errors surface at the next load or acknowledge, as st_tdre, st_ack or irq values that disagree with the bytes seen on the wire.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,   // both lines released
    PH_START,  // SDA low, SCL high
    PH_BLO,    // data bit, SCL low
    PH_BHI,    // data bit, SCL high
    PH_ALO,    // acknowledge slot, SCL low
    PH_AHI,    // acknowledge slot, SCL high
    PH_WAIT,   // parked between bytes, SCL low, SDA low
    PH_RLO,    // repeated start prep, SDA released, SCL low
    PH_RHI,    // repeated start prep, both released
    PH_PHI,    // stop: SCL high, SDA low
    PH_PEND    // stop: both released
  } phase_e;

  localparam int CB_START = 0;
  localparam int CB_STOP  = 1;
  localparam int CB_IEN   = 2;

  function automatic logic scl_pull(input phase_e p);
    case (p)
      PH_BLO, PH_ALO, PH_WAIT, PH_RLO: return 1'b1;
      default:                         return 1'b0;
    endcase
  endfunction

  function automatic logic sda_pull(input phase_e p, input logic msb);
    case (p)
      PH_START, PH_WAIT, PH_PHI: return 1'b1;
      PH_BLO, PH_BHI:            return ~msb;
      default:                   return 1'b0;
    endcase
  endfunction

  function automatic logic in_transfer(input phase_e p);
    return !(p == PH_IDLE || p == PH_PHI || p == PH_PEND);
  endfunction

endpackage

// File: rtl/i2cw_tick.sv
module i2cw_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam logic [DIV_W-1:0] MIN_LEN = DIV_W'(2);

  function automatic logic [DIV_W-1:0] phase_len(input logic [DIV_W-1:0] d);
    return (d < MIN_LEN) ? MIN_LEN : d;
  endfunction

  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= phase_len(div) - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/i2cw_regs.sv
module i2cw_regs
  import i2cw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_ctl,
  input  logic [7:0] wr_data,
  input  logic       ev_load,
  input  logic       ev_ack_ok,
  input  logic       ev_nack,
  input  logic       ev_start,
  input  logic       ev_restart,
  input  logic       ev_stop_done,
  input  logic       xfer,
  output logic [7:0] data_q,
  output logic       tdre,
  output logic       start_q,
  output logic       stop_q,
  output logic       ack,
  output logic       ackv,
  output logic       ncki,
  output logic       irq
);
  logic ien;
  logic dat_wr, ctl_wr;

  assign dat_wr = wr_en && !wr_ctl;
  assign ctl_wr = wr_en && wr_ctl;
  assign irq    = ien && (ncki || (tdre && xfer));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      tdre    <= 1'b1;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      ien     <= 1'b0;
      ack     <= 1'b0;
      ackv    <= 1'b0;
      ncki    <= 1'b0;
    end else begin
      if (dat_wr) data_q <= wr_data;

      if (dat_wr)                      tdre <= 1'b0;
      else if (ev_load)                tdre <= 1'b1;
      else if (ev_stop_done && ncki)   tdre <= 1'b1;

      if (ctl_wr && wr_data[CB_START]) start_q <= 1'b1;
      else if (ev_start)               start_q <= 1'b0;

      if (ctl_wr && wr_data[CB_STOP])  stop_q <= 1'b1;
      else if (ev_stop_done)           stop_q <= 1'b0;

      if (ctl_wr) ien <= wr_data[CB_IEN];

      if (ev_load) begin
        ack  <= 1'b0;
        ackv <= 1'b0;
      end else if (ev_ack_ok) begin
        ack  <= 1'b1;
        ackv <= 1'b1;
      end else if (ev_nack) begin
        ack  <= 1'b0;
        ackv <= 1'b1;
      end

      if (ev_nack)                          ncki <= 1'b1;
      else if (ev_stop_done || ev_restart)  ncki <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cw_fsm.sv
module i2cw_fsm
  import i2cw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [7:0] data_q,
  input  logic       tdre,
  input  logic       start_q,
  input  logic       stop_q,
  input  logic       ncki,
  input  logic       sda_i,
  output logic       ev_load,
  output logic       ev_ack_ok,
  output logic       ev_nack,
  output logic       ev_start,
  output logic       ev_restart,
  output logic       ev_stop_done,
  output logic       xfer,
  output logic       busy,
  output logic       hi_phase,
  output logic       scl_oe,
  output logic       sda_oe
);
  phase_e     ph, ph_n;
  logic [7:0] shreg;
  logic [2:0] bitc;
  logic       last_bit;

  assign last_bit = (bitc == 3'd7);
  assign scl_oe   = scl_pull(ph);
  assign xfer     = in_transfer(ph);
  assign busy     = (ph != PH_IDLE);
  assign hi_phase = (ph == PH_BHI) || (ph == PH_AHI);

  always_comb begin
    ph_n         = ph;
    ev_load      = 1'b0;
    ev_ack_ok    = 1'b0;
    ev_nack      = 1'b0;
    ev_start     = 1'b0;
    ev_restart   = 1'b0;
    ev_stop_done = 1'b0;
    if (tick) begin
      case (ph)
        PH_IDLE: begin
          if (start_q && !tdre) begin
            ph_n     = PH_START;
            ev_start = 1'b1;
          end else if (stop_q) begin
            ev_stop_done = 1'b1;
          end
        end
        PH_START: begin
          ph_n    = PH_BLO;
          ev_load = 1'b1;
        end
        PH_BLO: ph_n = PH_BHI;
        PH_BHI: ph_n = last_bit ? PH_ALO : PH_BLO;
        PH_ALO: ph_n = PH_AHI;
        PH_AHI: begin
          ph_n = PH_WAIT;
          if (!sda_i) ev_ack_ok = 1'b1;
          else        ev_nack   = 1'b1;
        end
        PH_WAIT: begin
          if (start_q && !tdre) begin
            ph_n       = PH_RLO;
            ev_restart = 1'b1;
          end else if (ncki) begin
            if (stop_q) ph_n = PH_PHI;
          end else if (!tdre) begin
            ph_n    = PH_BLO;
            ev_load = 1'b1;
          end else if (stop_q) begin
            ph_n = PH_PHI;
          end
        end
        PH_RLO: ph_n = PH_RHI;
        PH_RHI: begin
          ph_n     = PH_START;
          ev_start = 1'b1;
        end
        PH_PHI: ph_n = PH_PEND;
        PH_PEND: begin
          ph_n         = PH_IDLE;
          ev_stop_done = 1'b1;
        end
        default: ph_n = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      shreg  <= '0;
      bitc   <= '0;
      sda_oe <= 1'b0;
    end else begin
      ph     <= ph_n;
      // SDA follows the phase one clock late, so it moves only after SCL fell
      sda_oe <= sda_pull(ph, shreg[7]);
      if (ev_load) begin
        shreg <= data_q;
        bitc  <= '0;
      end else if (tick && ph == PH_BHI && !last_bit) begin
        shreg <= {shreg[6:0], 1'b0};
        bitc  <= bitc + 3'd1;
      end
    end
  end
endmodule

// File: rtl/i2c_wr_master.sv
module i2c_wr_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             wr_en,
  input  logic             wr_ctl,
  input  logic [7:0]       wr_data,
  output logic             st_tdre,
  output logic             st_ack,
  output logic             st_ackv,
  output logic             st_nack,
  output logic             st_start,
  output logic             st_stop,
  output logic             st_busy,
  output logic             irq,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_i
);
  logic       tick;
  logic [7:0] data_q;
  logic       ev_load, ev_ack_ok, ev_nack, ev_start, ev_restart, ev_stop_done;
  logic       xfer, hi_phase;

  i2cw_tick #(.DIV_W(DIV_W)) u_tick (
    .clk (clk),
    .rst_n (rst_n),
    .div (clk_div),
    .tick (tick)
  );

  i2cw_regs u_regs (
    .clk (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .wr_ctl (wr_ctl),
    .wr_data (wr_data),
    .ev_load (ev_load),
    .ev_ack_ok (ev_ack_ok),
    .ev_nack (ev_nack),
    .ev_start (ev_start),
    .ev_restart (ev_restart),
    .ev_stop_done (ev_stop_done),
    .xfer (xfer),
    .data_q (data_q),
    .tdre (st_tdre),
    .start_q (st_start),
    .stop_q (st_stop),
    .ack (st_ack),
    .ackv (st_ackv),
    .ncki (st_nack),
    .irq (irq)
  );

  i2cw_fsm u_fsm (
    .clk (clk),
    .rst_n (rst_n),
    .tick (tick),
    .data_q (data_q),
    .tdre (st_tdre),
    .start_q (st_start),
    .stop_q (st_stop),
    .ncki (st_nack),
    .sda_i (sda_i),
    .ev_load (ev_load),
    .ev_ack_ok (ev_ack_ok),
    .ev_nack (ev_nack),
    .ev_start (ev_start),
    .ev_restart (ev_restart),
    .ev_stop_done (ev_stop_done),
    .xfer (xfer),
    .busy (st_busy),
    .hi_phase (hi_phase),
    .scl_oe (scl_oe),
    .sda_oe (sda_oe)
  );
endmodule

// File: rtl/i2cw_chk.sv
module i2cw_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic wr_ctl,
  input logic st_tdre,
  input logic st_ack,
  input logic st_ackv,
  input logic st_nack,
  input logic st_start,
  input logic st_stop,
  input logic st_busy,
  input logic scl_oe,
  input logic sda_oe,
  input logic ev_load,
  input logic ev_ack_ok,
  input logic ev_start,
  input logic ev_stop_done,
  input logic hi_phase
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !st_busy |-> (!scl_oe && !sda_oe)); // R9

  AST_SDA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_phase && $past(hi_phase)) |-> $stable(sda_oe)); // R3

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start && !(wr_en && wr_ctl)) |=> !st_start); // R2

  AST_LOAD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_load && !(wr_en && !wr_ctl)) |=> st_tdre); // R4

  AST_ACK_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack_ok |=> (st_ack && st_ackv)); // R5

  AST_NACK_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_nack && !st_stop && !st_start) |-> scl_oe); // R6

  AST_NACK_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    st_nack |-> !ev_load); // R6

  AST_NACK_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop_done && st_nack && !wr_en) |=> (st_tdre && !st_nack && !st_stop)); // R7
endmodule

bind i2c_wr_master i2cw_chk u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .wr_en (wr_en),
  .wr_ctl (wr_ctl),
  .st_tdre (st_tdre),
  .st_ack (st_ack),
  .st_ackv (st_ackv),
  .st_nack (st_nack),
  .st_start (st_start),
  .st_stop (st_stop),
  .st_busy (st_busy),
  .scl_oe (scl_oe),
  .sda_oe (sda_oe),
  .ev_load (ev_load),
  .ev_ack_ok (ev_ack_ok),
  .ev_start (ev_start),
  .ev_stop_done (ev_stop_done),
  .hi_phase (hi_phase)
);

// File: tb/i2c_wr_master_tb.sv
module i2c_wr_master_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] clk_div = 8'd4;
  logic       wr_en = 1'b0;
  logic       wr_ctl = 1'b0;
  logic [7:0] wr_data = '0;
  logic st_tdre, st_ack, st_ackv, st_nack, st_start, st_stop, st_busy, irq;
  logic scl_oe, sda_oe, sda_i;
  logic pull = 1'b0;

  assign sda_i = ~(sda_oe | pull);

  always #5 clk = ~clk;

  i2c_wr_master #(.DIV_W(8)) u_dut (
    .clk (clk), .rst_n (rst_n), .clk_div (clk_div),
    .wr_en (wr_en), .wr_ctl (wr_ctl), .wr_data (wr_data),
    .st_tdre (st_tdre), .st_ack (st_ack), .st_ackv (st_ackv),
    .st_nack (st_nack), .st_start (st_start), .st_stop (st_stop),
    .st_busy (st_busy), .irq (irq),
    .scl_oe (scl_oe), .sda_oe (sda_oe), .sda_i (sda_i)
  );

  int errors = 0;
  int checks = 0;

  // bus monitor / slave model state
  logic [7:0] rx [0:63];
  int rx_n = 0, n_start = 0, n_stop = 0, glitch = 0, bad_len = 0;
  int bitn = 0, lenc = 0, exp_len = 4, nack_at = -1;
  logic [7:0] sh = '0;

  function automatic int phase_len(input int d);
    return (d < 2) ? 2 : d;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic ctl, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_ctl = ctl; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // bus monitor and acknowledging slave
  initial begin
    logic scl_p, sda_p, scl, sda;
    scl_p = 1'b1; sda_p = 1'b1;
    forever begin
      @(negedge clk);
      scl = ~scl_oe;
      sda = sda_i;
      lenc++;
      if (scl_p && scl && sda_p && !sda) begin
        n_start++; bitn = 0; pull = 1'b0;
      end else if (scl_p && scl && !sda_p && sda) begin
        n_stop++; bitn = 0;
      end else if (scl_p && scl && sda_p != sda && bitn >= 1 && bitn <= 7) begin
        glitch++;
      end
      if (!scl_p && scl) begin
        if (bitn >= 1 && bitn <= 8 && lenc != phase_len(exp_len)) bad_len++;
        lenc = 0;
        if (bitn < 8) begin
          sh = {sh[6:0], sda};
          bitn++;
          if (bitn == 8) begin
            rx[rx_n] = sh;
            rx_n++;
          end
        end else if (bitn == 8) begin
          bitn = 9;
        end
      end else if (scl_p && !scl) begin
        if (bitn >= 1 && bitn <= 9 && lenc != phase_len(exp_len)) bad_len++;
        lenc = 0;
        if (bitn == 8)      pull = (rx_n - 1 != nack_at);
        else if (bitn == 9) begin pull = 1'b0; bitn = 0; end
      end
      scl_p = scl; sda_p = sda;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] exp_b [0:63];
    int base, ns, ns0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(scl_oe == 0 && sda_oe == 0, "R1 pins", {scl_oe, sda_oe}, 0);
    chk(st_tdre == 1 && st_busy == 0 && irq == 0, "R1 status", {st_tdre, st_busy, irq}, 3'b100);
    chk({st_ack, st_ackv, st_nack, st_start, st_stop} == 0, "R1 flags",
        {st_ack, st_ackv, st_nack, st_start, st_stop}, 0);
    rst_n = 1'b1;

    // Test A: 7-bit write, div 4
    clk_div = 8'd4; exp_len = 4;
    exp_b[0] = 8'hA6; exp_b[1] = 8'h3C;
    wr(1'b0, 8'hA6);
    wr(1'b1, 8'h05);
    wait (n_start == 1);
    @(negedge clk);
    chk(st_start == 0, "R2 start bit cleared", st_start, 0);
    wait (st_tdre);
    @(negedge clk);
    chk(irq == 1, "R4 irq on empty data", irq, 1);
    chk(scl_oe == 1, "R2 SCL low after start", scl_oe, 1);
    wr(1'b0, 8'h3C);
    chk(irq == 0, "R4 irq drops on write", irq, 0);
    wait (rx_n == 2);
    wait (st_ackv);
    repeat (40) @(negedge clk);
    chk(scl_oe == 1 && rx_n == 2, "R8 SCL held low when empty", rx_n, 2);
    chk(st_ack == 1 && st_ackv == 1, "R5 ack latched", {st_ack, st_ackv}, 2'b11);
    for (int i = 2; i < 8; i++) begin
      exp_b[i] = 8'($urandom());
      wr(1'b0, exp_b[i]);
      wait (st_tdre);
    end
    wait (rx_n == 8);
    wait (st_ackv);
    wr(1'b1, 8'h06);
    wait (!st_busy);
    @(negedge clk);
    chk(n_stop == 1, "R9 stop on bus", n_stop, 1);
    chk(st_stop == 0 && scl_oe == 0 && sda_oe == 0, "R9 idle released",
        {st_stop, scl_oe, sda_oe}, 0);
    chk(irq == 0, "R4 irq idle", irq, 0);
    for (int i = 0; i < 8; i++)
      chk(rx[i] == exp_b[i], "R3 byte order", rx[i], exp_b[i]);
    chk(glitch == 0, "R3 SDA steady while SCL high", glitch, 0);
    chk(bad_len == 0, "R11 phase length div4", bad_len, 0);

    // Test B: 10-bit address, divider below floor
    clk_div = 8'd1; exp_len = 1;
    base = rx_n;
    wr(1'b0, 8'hF4);
    wr(1'b1, 8'h05);
    wait (st_tdre);
    wr(1'b0, 8'h5A);
    wait (st_tdre);
    wr(1'b0, 8'h81);
    wait (st_tdre);
    wait (rx_n == base + 3);
    wait (st_ackv);
    wr(1'b1, 8'h06);
    wait (!st_busy);
    chk(rx[base] == 8'hF4, "R3 10-bit first address", rx[base], 8'hF4);
    chk(rx[base+1] == 8'h5A, "R3 10-bit second address", rx[base+1], 8'h5A);
    chk(rx[base+2] == 8'h81, "R3 10-bit data", rx[base+2], 8'h81);
    chk(bad_len == 0, "R11 phase length floor", bad_len, 0);

    // Test C: NACK on data byte, pending byte flushed by STOP
    clk_div = 8'd3; exp_len = 3;
    base = rx_n; nack_at = base + 1; ns0 = n_stop;
    wr(1'b0, 8'h52);
    wr(1'b1, 8'h05);
    wait (st_tdre);
    wr(1'b0, 8'hD1);
    wait (st_tdre);
    wr(1'b0, 8'hEE);
    wait (st_nack);
    @(negedge clk);
    chk(st_ack == 0 && st_ackv == 1, "R6 nack status", {st_ack, st_ackv}, 2'b01);
    chk(irq == 1, "R6 nack irq", irq, 1);
    repeat (60) @(negedge clk);
    chk(rx_n == base + 2, "R6 no byte after nack", rx_n, base + 2);
    chk(scl_oe == 1 && st_tdre == 0, "R6 parked with byte pending", {scl_oe, st_tdre}, 2'b10);
    wr(1'b1, 8'h06);
    wait (!st_busy);
    @(negedge clk);
    chk(st_tdre == 1, "R7 pending byte flushed", st_tdre, 1);
    chk(st_nack == 0 && st_stop == 0, "R7 flags cleared", {st_nack, st_stop}, 0);
    chk(n_stop == ns0 + 1 && rx_n == base + 2, "R7 stop sent, byte dropped", n_stop, ns0 + 1);
    nack_at = -1;

    // Test D: NACK on address, repeated START, then plain repeated START
    base = rx_n; nack_at = base;
    wr(1'b0, 8'h90);
    wr(1'b1, 8'h05);
    wait (st_nack);
    nack_at = -1;
    ns = n_start;
    wr(1'b1, 8'h05);
    wr(1'b0, 8'h92);
    wait (n_start == ns + 1);
    @(negedge clk);
    chk(st_nack == 0, "R10 restart clears nack", st_nack, 0);
    wait (rx_n == base + 2);
    wait (st_ackv);
    chk(st_ack == 1 && rx[base+1] == 8'h92, "R10 byte after restart", rx[base+1], 8'h92);
    wr(1'b1, 8'h05);
    wr(1'b0, 8'h94);
    wait (n_start == ns + 2);
    wait (rx_n == base + 3);
    wait (st_ackv);
    chk(rx[base+2] == 8'h94 && st_ack == 1, "R10 plain repeated start", rx[base+2], 8'h94);
    wr(1'b1, 8'h06);
    wait (!st_busy);
    @(negedge clk);
    chk(scl_oe == 0 && sda_oe == 0, "R9 idle after restart sequence", {scl_oe, sda_oe}, 0);
    chk(glitch == 0 && bad_len == 0, "R11 R3 timing overall", glitch + bad_len, 0);
    finish_run();
  end
endmodule